// File: doc/BRIEF.md
# Masked Event Flag Combiner

This block turns a wide vector of system event pulses into sticky flag bits. The flags are grouped in banks, four banks of 32 by default. A rising edge on an event input sets its flag. The flag stays set until software writes a 1 to the matching bit of the flag clear word.

Each bank has its own event mask word. The block ORs the flags that the mask leaves open into one combined level per bank. A second, independent set of exception mask words, one per bank, merges the open flags of every bank into a single exception level. Bits 0 to 3 of bank 0 are reserved for the combined outputs themselves and never feed either tree.

Both output trees are registered. No detection of dropped or repeated events is provided for the combined outputs. Software reaches the flags and masks through a word-addressed write/read port, with one 32-bit word per bank and per register group.

Top module: `masked_event_combiner`

## Requirements
- R1: After reset every flag is 0, every event mask bit and every exception mask bit is 1, and `comb_o` and `exc_o` are 0.
- R2: A 0-to-1 transition of `evt_i[n]` between two clock edges sets flag n. An input held high does not set its flag again after the flag has been cleared.
- R3: A flag stays set until a write to its flag word has a 1 in its bit position. Writing a 0 to that bit leaves the flag unchanged.
- R4: When a rising event and a clear of the same flag fall on the same clock edge, the flag ends up set.
- R5: Reading the flag word of bank b returns the raw flags of events 32b+31 down to 32b, with event 32b+j in bit j, whatever the masks hold.
- R6: `comb_o[k]` is the OR of the bank-k flags whose event mask bit is 0. A mask bit of 1 removes that flag.
- R7: Flags 0 to 3 (bank 0, bits 0 to 3) never drive `comb_o` or `exc_o`, whatever the masks hold.
- R8: `exc_o` is the OR of all flags 127 down to 4 whose exception mask bit is 0. The exception masks are independent of the event masks.
- R9: `comb_o` and `exc_o` follow a change of the flags or masks on the clock edge after that change. A flag set or cleared on edge e, or a mask written on edge e, shows at the outputs after edge e+1.
- R10: Address `{grp[1:0], bank[1:0]}` selects the register. Group 0 is the flags: a write clears bits, a read returns the flags. Group 1 is the event masks and group 2 the exception masks, both read/write. Group 3 reads as 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 128 | System event inputs |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Word address: group in [3:2], bank in [1:0] |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| comb_o | output | 4 | Per-bank combined event levels |
| exc_o | output | 1 | Global exception level |

## Verification
A flag that is lost or set by mistake shows directly on the flag read word. Two edges after the event it also shows on the combined or exception level, provided its mask bit is open. A mask bit stuck at the wrong value shows up the next time its read word is read. It also shows as a missing or spurious output level one edge after the mask write. The sweeps set and clear every event bit alone under each tree, so a misplaced bit or bank shows at once. At each step they sample the edge before and the edge after the output register, which exposes any extra or missing register stage.

// File: rtl/evcomb_pkg.sv
package evcomb_pkg;
  typedef enum logic [1:0] {
    GRP_FLAG  = 2'd0,
    GRP_EMASK = 2'd1,
    GRP_XMASK = 2'd2,
    GRP_NONE  = 2'd3
  } reg_grp_e;
endpackage

// File: rtl/evcomb_flags.sv
module evcomb_flags #(
  parameter int NB = 4,
  parameter int BW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NB*BW-1:0] evt_i,
  input  logic [NB*BW-1:0] clr_i,
  output logic [NB*BW-1:0] flag_o
);
  localparam int EW = NB * BW;

  logic [EW-1:0] evt_prev_q, flag_q, flag_d;

  // Next state: set on a rising edge, and the set beats a clear
  always_comb begin
    flag_d = (flag_q & ~clr_i) | (evt_i & ~evt_prev_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_prev_q <= '0;
      flag_q     <= '0;
    end else begin
      evt_prev_q <= evt_i;
      flag_q     <= flag_d;
    end
  end

  assign flag_o = flag_q;

  // R3: a set flag only drops for a bit that was being cleared
  p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(flag_q) & ~$past(clr_i)) & ~flag_q) == '0));

  // R2: a rising edge on an input always leaves its flag set
  p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(evt_i & ~evt_prev_q) & ~flag_q) == '0));
endmodule

// File: rtl/evcomb_regs.sv
module evcomb_regs
  import evcomb_pkg::*;
#(
  parameter int NB = 4,
  parameter int BW = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en_i,
  input  logic [$clog2(NB)+1:0]       addr_i,
  input  logic [BW-1:0]               wdata_i,
  input  logic [NB*BW-1:0]            flag_i,
  output logic [NB*BW-1:0]            emask_o,
  output logic [NB*BW-1:0]            xmask_o,
  output logic [NB*BW-1:0]            clr_o,
  output logic [BW-1:0]               rdata_o
);
  localparam int SW = $clog2(NB);

  reg_grp_e        grp;
  logic [SW-1:0]   bsel;

  assign grp  = reg_grp_e'(addr_i[SW+1:SW]);
  assign bsel = addr_i[SW-1:0];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic          hit;
    logic [BW-1:0] em_q, em_d, xm_q, xm_d;

    assign hit = wr_en_i && (bsel == SW'(b));

    always_comb begin
      em_d = em_q;
      xm_d = xm_q;
      if (hit && grp == GRP_EMASK) em_d = wdata_i;
      if (hit && grp == GRP_XMASK) xm_d = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        em_q <= '1;
        xm_q <= '1;
      end else begin
        em_q <= em_d;
        xm_q <= xm_d;
      end
    end

    assign emask_o[b*BW +: BW] = em_q;
    assign xmask_o[b*BW +: BW] = xm_q;
    assign clr_o[b*BW +: BW]   = (hit && grp == GRP_FLAG) ? wdata_i : '0;
  end

  always_comb begin
    unique case (grp)
      GRP_FLAG:  rdata_o = flag_i[bsel*BW +: BW];
      GRP_EMASK: rdata_o = emask_o[bsel*BW +: BW];
      GRP_XMASK: rdata_o = xmask_o[bsel*BW +: BW];
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/evcomb_tree.sv
module evcomb_tree #(
  parameter int NB  = 4,
  parameter int BW  = 32,
  parameter int RSV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NB*BW-1:0] flag_i,
  input  logic [NB*BW-1:0] emask_i,
  input  logic [NB*BW-1:0] xmask_i,
  output logic [NB-1:0]    comb_o,
  output logic             exc_o
);
  localparam logic [BW-1:0] KEEP0 = ~BW'((64'd1 << RSV) - 64'd1);

  logic [NB-1:0] comb_d, comb_q, xpart;
  logic          exc_d, exc_q;

  for (genvar k = 0; k < NB; k++) begin : g_bank
    localparam logic [BW-1:0] KEEP = (k == 0) ? KEEP0 : {BW{1'b1}};
    logic [BW-1:0] fl;
    assign fl       = flag_i[k*BW +: BW] & KEEP;
    assign comb_d[k] = |(fl & ~emask_i[k*BW +: BW]);
    assign xpart[k]  = |(fl & ~xmask_i[k*BW +: BW]);
  end

  assign exc_d = |xpart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comb_q <= '0;
      exc_q  <= 1'b0;
    end else begin
      comb_q <= comb_d;
      exc_q  <= exc_d;
    end
  end

  assign comb_o = comb_q;
  assign exc_o  = exc_q;

  // R6: any combined level has a set flag behind it one edge earlier
  p_comb_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|comb_q) |-> $past(|flag_i));

  // R8: the exception level has a set flag behind it one edge earlier
  p_exc_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_q |-> $past(|(flag_i[NB*BW-1:RSV])));

  // R7: bank 0 only fires from flags above the reserved range
  p_rsv_excluded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    comb_q[0] |-> $past(|(flag_i[BW-1:RSV])));
endmodule

// File: rtl/masked_event_combiner.sv
module masked_event_combiner #(
  parameter int NB  = 4,
  parameter int BW  = 32,
  parameter int RSV = 4,
  localparam int EW = NB * BW,
  localparam int AW = $clog2(NB) + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [EW-1:0] evt_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [BW-1:0] wdata_i,
  output logic [BW-1:0] rdata_o,
  output logic [NB-1:0] comb_o,
  output logic          exc_o
);
  logic [EW-1:0] flag, emask, xmask, clr;

  evcomb_flags #(.NB(NB), .BW(BW)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_i(clr), .flag_o(flag)
  );

  evcomb_regs #(.NB(NB), .BW(BW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .flag_i(flag), .emask_o(emask), .xmask_o(xmask),
    .clr_o(clr), .rdata_o(rdata_o)
  );

  evcomb_tree #(.NB(NB), .BW(BW), .RSV(RSV)) u_tree (
    .clk(clk), .rst_n(rst_n), .flag_i(flag), .emask_i(emask),
    .xmask_i(xmask), .comb_o(comb_o), .exc_o(exc_o)
  );
endmodule

// File: tb/masked_event_combiner_bench.sv
module masked_event_combiner_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [127:0] evt;
  logic         wr_en;
  logic [3:0]   addr;
  logic [31:0]  wdata;
  logic [31:0]  rdata;
  logic [3:0]   comb;
  logic         exc;
  int           total = 0;
  int           bad = 0;

  always #2 clk = ~clk;

  masked_event_combiner u_masked_event_combiner (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .comb_o(comb), .exc_o(exc)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; evt = '0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk({27'd0, comb, exc}, 32'd0, "R1 outputs");
    for (int b = 0; b < 4; b++) begin
      rd(4'(b), r);     chk(r, 32'd0, "R1 flags");
      rd(4'(4 + b), r); chk(r, 32'hffff_ffff, "R1 emask");
      rd(4'(8 + b), r); chk(r, 32'hffff_ffff, "R1 xmask");
    end

    // R6 with all masked: flag set (R5 raw read) but no output
    @(negedge clk) evt[40] = 1'b1;
    @(negedge clk) evt[40] = 1'b0;
    @(negedge clk);
    chk({28'd0, comb}, 32'd0, "R6 masked");
    rd(4'd1, r); chk(r, 32'h100, "R5 raw");
    wr(4'd1, 32'h100);

    // Event mask sweep over every bit
    for (int b = 0; b < 4; b++) wr(4'(4 + b), 32'd0);
    for (int i = 0; i < 128; i++) begin
      logic [3:0] ex;
      ex = (i >= 4) ? 4'(1 << (i / 32)) : 4'd0;
      evt[i] = 1'b1;
      @(negedge clk) evt[i] = 1'b0;
      rd(4'(i / 32), r); chk(r, 32'd1 << (i % 32), "R2 set");
      chk({28'd0, comb}, 32'd0, "R9 comb lag");
      @(negedge clk);
      chk({28'd0, comb}, {28'd0, ex}, "R6 R7 comb");
      chk({31'd0, exc}, 32'd0, "R8 exc masked");
      wr(4'(i / 32), 32'd0);
      rd(4'(i / 32), r); chk(r, 32'd1 << (i % 32), "R3 zero write");
      wr(4'(i / 32), 32'd1 << (i % 32));
      rd(4'(i / 32), r); chk(r, 32'd0, "R3 clear");
      chk({28'd0, comb}, {28'd0, ex}, "R9 clear lag");
      @(negedge clk);
      chk({28'd0, comb}, 32'd0, "R6 cleared");
    end

    // Exception mask sweep
    for (int b = 0; b < 4; b++) begin
      wr(4'(4 + b), 32'hffff_ffff);
      wr(4'(8 + b), 32'd0);
    end
    for (int i = 0; i < 128; i++) begin
      evt[i] = 1'b1;
      @(negedge clk) evt[i] = 1'b0;
      @(negedge clk);
      chk({31'd0, exc}, {31'd0, i >= 4}, "R8 R7 exc");
      chk({28'd0, comb}, 32'd0, "R8 independent");
      wr(4'(i / 32), 32'd1 << (i % 32));
      @(negedge clk);
      chk({31'd0, exc}, 32'd0, "R8 cleared");
    end

    // R4 set beats clear, then R2 held level does not re-set
    evt[70] = 1'b1;
    wr(4'd2, 32'h40);
    rd(4'd2, r); chk(r, 32'h40, "R4 set wins");
    wr(4'd2, 32'h40);
    repeat (3) @(negedge clk);
    rd(4'd2, r); chk(r, 32'd0, "R2 held level");
    evt[70] = 1'b0;
    @(negedge clk);

    // R9 mask latency and per-bit masking on exception tree
    for (int b = 0; b < 4; b++) wr(4'(8 + b), 32'hffff_ffff);
    evt[100] = 1'b1;
    @(negedge clk) evt[100] = 1'b0;
    @(negedge clk);
    chk({31'd0, exc}, 32'd0, "R8 masked");
    wr(4'd11, ~(32'd1 << 4));
    chk({31'd0, exc}, 32'd0, "R9 mask lag");
    @(negedge clk);
    chk({31'd0, exc}, 32'd1, "R8 unmasked");
    wr(4'd11, ~(32'd1 << 5));
    @(negedge clk);
    chk({31'd0, exc}, 32'd0, "R8 other bit");

    // R10 group 3 reads zero and ignores writes
    wr(4'd12, 32'hffff_ffff);
    wr(4'd15, 32'hffff_ffff);
    rd(4'd12, r); chk(r, 32'd0, "R10 group3 read");
    rd(4'd11, r); chk(r, ~(32'd1 << 5), "R10 xmask kept");
    rd(4'd7, r);  chk(r, 32'hffff_ffff, "R10 emask kept");
    rd(4'd3, r);  chk(r, 32'h10, "R10 flags kept");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule